// File: doc/BRIEF.md
# MMU Control Register File

This block holds the memory-management and exception state registers of a processor core. It sits on a simple register bus that moves one 32-bit word per request. A write to a register can also send a single-cycle command to an external translation lookaside buffer (TLB). Setting the invalidate bit in the control register orders a full invalidate. Changing the address-space identifier held in the page-table-entry-high register orders a full flush.

The registers are the control word, the page-table-entry high, low and assist words, the translation table base, the faulting address, the trap code, the exception event code and the interrupt event code. Several of them implement only a narrow field, and a write to one of them keeps only that field. The exception logic of the core can load the two event codes through a separate update port, and that port wins over a bus write in the same cycle. A byte or halfword access, an address that is not word aligned, or an address that maps to no register is rejected with an error pulse and changes nothing.

Top module: `mmu_ctrl_regs`

## Requirements
- R1: After reset every register reads 0, and `tlb_inv_o`, `tlb_flush_o` and `err_o` are low.
- R2: A legal write to the control register (byte offset 0x00) whose data bit 2 is 1 makes `tlb_inv_o` high for exactly the one cycle after the write. Bit 2 always reads back as 0 and every other bit is stored. When data bit 2 is 0, no pulse is emitted.
- R3: A legal write to page-table-entry high (offset 0x04) stores all 32 bits. It makes `tlb_flush_o` high for the one cycle after the write only when data bits [7:0] differ from the stored bits [7:0].
- R4: Page-table-entry assist (offset 0x0C) keeps only data bits [3:0]. All higher bits read as 0.
- R5: Trap code (0x18), exception event code (0x1C) and interrupt event code (0x20) keep only data bits [10:0]. All higher bits read as 0.
- R6: Page-table-entry low (0x08), translation table base (0x10) and faulting address (0x14) store the full 32-bit word.
- R7: An access whose `size_i` is not 2 (0 is byte, 1 is halfword, 3 is reserved), whose address bits [1:0] are not 0, or whose offset is 0x24 or higher makes `err_o` high for the one cycle after the request. Such an access changes no register and emits no TLB pulse, and a rejected read returns 0 on `rdata_o`.
- R8: When `evt_upd_i` is high, the exception and interrupt event codes load `evt_exc_i` and `evt_irq_i`. This takes priority over a bus write to either register in the same cycle.
- R9: A legal read places the register value on `rdata_o` in the cycle after the request. A read issued right after a write returns the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus request valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte offset of the access |
| size_i | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid the cycle after a read request |
| err_o | output | 1 | Access error pulse |
| tlb_inv_o | output | 1 | TLB invalidate-all pulse |
| tlb_flush_o | output | 1 | TLB flush pulse on an address-space identifier change |
| evt_upd_i | input | 1 | Hardware load of the event codes |
| evt_exc_i | input | 11 | Exception event code from the core |
| evt_irq_i | input | 11 | Interrupt event code from the core |

## Verification
The assertions check four properties on every cycle. The control register's invalidate bit is never stored. The narrow registers never hold bits above their field. A flush pulse appears exactly when the stored address-space identifier byte changes. A rejected access leaves every register untouched.

Only the bench scenarios show the rest. That covers the actual stored values after each kind of write and the one-cycle read latency. It also covers the pulse width after back-to-back traffic and the priority of a hardware event load over a bus write in the same cycle.

// File: rtl/mmu_regs_pkg.sv
package mmu_regs_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned CODE_W  = 11;
  localparam int unsigned ASID_W  = 8;
  localparam int unsigned INV_BIT = 2;
  localparam int unsigned NREG    = 9;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } acc_size_e;

  typedef enum int unsigned {
    RI_CTRL   = 0,
    RI_PTEH   = 1,
    RI_PTEL   = 2,
    RI_ASSIST = 3,
    RI_TBASE  = 4,
    RI_FAULT  = 5,
    RI_TRAP   = 6,
    RI_EXC    = 7,
    RI_IRQ    = 8
  } reg_idx_e;

  function automatic logic [DATA_W-1:0] reg_mask(int unsigned idx);
    case (idx)
      RI_CTRL:                 return ~(DATA_W'(1) << INV_BIT);
      RI_ASSIST:               return DATA_W'(32'hF);
      RI_TRAP, RI_EXC, RI_IRQ: return DATA_W'((1 << CODE_W) - 1);
      default:                 return '1;
    endcase
  endfunction
endpackage

// File: rtl/mmu_reg_decode.sv
module mmu_reg_decode #(
  parameter int unsigned ADDR_W = 6,
  localparam int unsigned IDX_W = ADDR_W - 2
) (
  input  logic              req_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        size_i,
  output logic              ok_o,
  output logic              err_o,
  output logic [IDX_W-1:0]  idx_o
);
  import mmu_regs_pkg::*;

  logic legal;

  assign idx_o = addr_i[ADDR_W-1:2];
  assign legal = (size_i == SZ_WORD) && (addr_i[1:0] == 2'b00) &&
                 (int'(idx_o) < int'(NREG));
  assign ok_o  = req_i && legal;
  assign err_o = req_i && !legal;
endmodule

// File: rtl/mmu_reg_slot.sv
module mmu_reg_slot #(
  parameter logic [31:0] MASK = '1
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        bus_we_i,
  input  logic [31:0] bus_d_i,
  input  logic        hw_we_i,
  input  logic [31:0] hw_d_i,
  output logic [31:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       q_o <= '0;
    else if (hw_we_i)  q_o <= hw_d_i & MASK;   // core-side load wins
    else if (bus_we_i) q_o <= bus_d_i & MASK;
  end
endmodule

// File: rtl/mmu_side_fx.sv
module mmu_side_fx #(
  parameter int unsigned ASID_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_wr_i,
  input  logic              inv_req_i,
  input  logic              pteh_wr_i,
  input  logic [ASID_W-1:0] asid_new_i,
  input  logic [ASID_W-1:0] asid_old_i,
  output logic              inv_o,
  output logic              flush_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_o   <= 1'b0;
      flush_o <= 1'b0;
    end else begin
      inv_o   <= ctrl_wr_i && inv_req_i;
      flush_o <= pteh_wr_i && (asid_new_i != asid_old_i);
    end
  end
endmodule

// File: rtl/mmu_ctrl_regs.sv
module mmu_ctrl_regs #(
  parameter int unsigned ADDR_W = 6
) (
  input  logic                            clk_i,
  input  logic                            rst_ni,
  input  logic                            req_i,
  input  logic                            we_i,
  input  logic [ADDR_W-1:0]               addr_i,
  input  logic [1:0]                      size_i,
  input  logic [31:0]                     wdata_i,
  output logic [31:0]                     rdata_o,
  output logic                            err_o,
  output logic                            tlb_inv_o,
  output logic                            tlb_flush_o,
  input  logic                            evt_upd_i,
  input  logic [mmu_regs_pkg::CODE_W-1:0] evt_exc_i,
  input  logic [mmu_regs_pkg::CODE_W-1:0] evt_irq_i
);
  import mmu_regs_pkg::*;
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic             acc_ok, acc_err, wr_ok;
  logic [IDX_W-1:0] acc_idx;
  logic [31:0]      q [NREG];
  logic [31:0]      rd_mux;

  mmu_reg_decode #(.ADDR_W(ADDR_W)) i_decode (
    .req_i (req_i),
    .addr_i(addr_i),
    .size_i(size_i),
    .ok_o  (acc_ok),
    .err_o (acc_err),
    .idx_o (acc_idx)
  );

  assign wr_ok = acc_ok && we_i;

  for (genvar i = 0; i < NREG; i++) begin : g_slot
    logic        hw_we;
    logic [31:0] hw_d;
    if (i == RI_EXC) begin : g_exc
      assign hw_we = evt_upd_i;
      assign hw_d  = 32'(evt_exc_i);
    end else if (i == RI_IRQ) begin : g_irq
      assign hw_we = evt_upd_i;
      assign hw_d  = 32'(evt_irq_i);
    end else begin : g_bus_only
      assign hw_we = 1'b0;
      assign hw_d  = '0;
    end
    mmu_reg_slot #(.MASK(reg_mask(i))) i_slot (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .bus_we_i(wr_ok && (acc_idx == IDX_W'(i))),
      .bus_d_i (wdata_i),
      .hw_we_i (hw_we),
      .hw_d_i  (hw_d),
      .q_o     (q[i])
    );
  end

  mmu_side_fx #(.ASID_W(ASID_W)) i_side_fx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_wr_i (wr_ok && (acc_idx == IDX_W'(RI_CTRL))),
    .inv_req_i (wdata_i[INV_BIT]),
    .pteh_wr_i (wr_ok && (acc_idx == IDX_W'(RI_PTEH))),
    .asid_new_i(wdata_i[ASID_W-1:0]),
    .asid_old_i(q[RI_PTEH][ASID_W-1:0]),
    .inv_o     (tlb_inv_o),
    .flush_o   (tlb_flush_o)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NREG; i++)
      if (acc_idx == IDX_W'(i)) rd_mux = q[i];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_o <= '0;
      err_o   <= 1'b0;
    end else begin
      err_o <= acc_err;
      if (acc_ok && !we_i)       rdata_o <= rd_mux;
      else if (acc_err && !we_i) rdata_o <= '0;
    end
  end

  logic [32*NREG-1:0] all_q;
  always_comb
    for (int i = 0; i < NREG; i++) all_q[32*i +: 32] = q[i];

  assert_inv_bit_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !q[RI_CTRL][INV_BIT]);
  assert_single_pulse_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tlb_inv_o, tlb_flush_o}));
  assert_flush_on_asid_change_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tlb_flush_o |-> (q[RI_PTEH][7:0] != $past(q[RI_PTEH][7:0])));
  assert_asid_change_flushes_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[RI_PTEH][7:0] != $past(q[RI_PTEH][7:0])) |-> tlb_flush_o);
  assert_assist_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q[RI_ASSIST][31:4] == '0);
  assert_code_width_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (q[RI_TRAP][31:11] == '0) && (q[RI_EXC][31:11] == '0) && (q[RI_IRQ][31:11] == '0));
  assert_err_no_update_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err_o && !$past(evt_upd_i)) |-> ($stable(all_q) && !tlb_inv_o && !tlb_flush_o));
endmodule

// File: tb/test_mmu_ctrl_regs.sv
module test_mmu_ctrl_regs;
  logic        clk = 0, rst_ni = 0;
  logic        req = 0, we = 0, upd = 0;
  logic [5:0]  addr = 0;
  logic [1:0]  size = 0;
  logic [31:0] wdata = 0;
  logic [10:0] ev_exc = 0, ev_irq = 0;
  logic [31:0] rdata;
  logic        err, inv, flush;

  mmu_ctrl_regs i_mmu_ctrl_regs (
    .clk_i(clk), .rst_ni(rst_ni), .req_i(req), .we_i(we), .addr_i(addr),
    .size_i(size), .wdata_i(wdata), .rdata_o(rdata), .err_o(err),
    .tlb_inv_o(inv), .tlb_flush_o(flush), .evt_upd_i(upd),
    .evt_exc_i(ev_exc), .evt_irq_i(ev_irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    bit          chk_rd;
    logic [31:0] rd;
    bit          e, i, f;
    string       tag;
  } item_t;

  item_t       sb[$];
  int          cyc = 0, checks = 0, fails = 0;
  logic [31:0] m [9];

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] mask_of(int r);
    if (r == 0) return 32'hFFFF_FFFB;
    if (r == 3) return 32'h0000_000F;
    if (r >= 6) return 32'h0000_07FF;
    return 32'hFFFF_FFFF;
  endfunction

  function automatic bit legal(logic [5:0] a, logic [1:0] s);
    return s == 2'd2 && a[1:0] == 2'b00 && a < 6'h24;
  endfunction

  task automatic push(bit c, logic [31:0] r, bit e, bit i, bit f, string t);
    item_t it;
    it.due = cyc + 1; it.chk_rd = c; it.rd = r; it.e = e; it.i = i; it.f = f; it.tag = t;
    sb.push_back(it);
  endtask

  task automatic wr(logic [5:0] a, logic [31:0] d, string t, logic [1:0] s = 2'd2,
                    bit hw = 0, logic [10:0] hx = 0, logic [10:0] hq = 0);
    bit ok, ei, ef;
    int r;
    @(negedge clk);
    req = 1; we = 1; addr = a; size = s; wdata = d;
    upd = hw; ev_exc = hx; ev_irq = hq;
    ok = legal(a, s); r = int'(a >> 2);
    ei = ok && r == 0 && d[2];
    ef = ok && r == 1 && d[7:0] != m[1][7:0];
    if (ok) m[r] = d & mask_of(r);
    if (hw) begin m[7] = 32'(hx); m[8] = 32'(hq); end
    push(0, 0, !ok, ei, ef, t);
  endtask

  task automatic rd(logic [5:0] a, string t, logic [1:0] s = 2'd2);
    bit ok;
    @(negedge clk);
    req = 1; we = 0; addr = a; size = s; wdata = 0; upd = 0;
    ok = legal(a, s);
    push(1, ok ? m[int'(a >> 2)] : 32'h0, !ok, 0, 0, t);
  endtask

  task automatic idle(string t);
    @(negedge clk);
    req = 0; we = 0; upd = 0;
    push(0, 0, 0, 0, 0, t);
  endtask

  always @(negedge clk) begin
    if (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      checks++;
      if (err !== it.e || inv !== it.i || flush !== it.f ||
          (it.chk_rd && rdata !== it.rd)) begin
        fails++;
        $display("FAIL %s: rdata=%h err=%b inv=%b flush=%b expected rdata=%h err=%b inv=%b flush=%b",
                 it.tag, rdata, err, inv, flush, it.rd, it.e, it.i, it.f);
      end
    end
  end

  initial begin
    #2_000_000;
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int k = 0; k < 9; k++) m[k] = 0;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    @(negedge clk);
    checks++;
    if (err !== 0 || inv !== 0 || flush !== 0 || rdata !== 0) begin
      fails++;
      $display("FAIL R1: err=%b inv=%b flush=%b rdata=%h expected 0 0 0 0", err, inv, flush, rdata);
    end
    for (int k = 0; k < 9; k++) rd(6'(k * 4), "R1 reset value");

    // R2 invalidate bit
    wr(6'h00, 32'hFFFF_FFFF, "R2 invalidate pulse");
    idle("R2 pulse one cycle");
    rd(6'h00, "R2 bit cleared on readback");
    wr(6'h00, 32'h0000_00F1, "R2 no pulse without bit");
    rd(6'h00, "R2 other bits kept");
    wr(6'h00, 32'h0000_0004, "R2 second invalidate");
    wr(6'h00, 32'h0000_0004, "R2 back-to-back invalidate");
    idle("R2 pulse ends");

    // R3 asid flush
    wr(6'h04, 32'h0000_1234, "R3 asid change flush");
    rd(6'h04, "R3 full store");
    wr(6'h04, 32'hABCD_0034, "R3 same asid no flush");
    rd(6'h04, "R3 upper bits stored");
    wr(6'h04, 32'hABCD_0000, "R3 asid back to zero flush");
    idle("R3 flush one cycle");

    // R4, R5 truncation
    wr(6'h0C, 32'hFFFF_FFFF, "R4 assist write");
    rd(6'h0C, "R4 assist truncated");
    wr(6'h18, 32'hFFFF_FFFF, "R5 trap write");
    wr(6'h1C, 32'hA5A5_FC3C, "R5 exc write");
    wr(6'h20, 32'h1234_5678, "R5 irq write");
    rd(6'h18, "R5 trap truncated");
    rd(6'h1C, "R5 exc truncated");
    rd(6'h20, "R5 irq truncated");

    // R6 full registers, R9 read after write
    wr(6'h08, 32'hDEAD_BEEF, "R6 pte low write");
    rd(6'h08, "R9 R6 pte low read after write");
    wr(6'h10, 32'h8000_0001, "R6 table base write");
    rd(6'h10, "R6 table base");
    wr(6'h14, 32'h7FFF_FFFE, "R6 fault addr write");
    rd(6'h14, "R6 fault addr");

    // R7 rejected accesses
    wr(6'h08, 32'h1111_1111, "R7 byte write rejected", 2'd0);
    rd(6'h08, "R7 byte write left register");
    rd(6'h10, "R7 halfword read rejected", 2'd1);
    wr(6'h24, 32'hFFFF_FFFF, "R7 unmapped write");
    wr(6'h06, 32'hFFFF_FFFF, "R7 misaligned write");
    wr(6'h3C, 32'h5555_5555, "R7 top unmapped write");
    wr(6'h00, 32'hFFFF_FFFF, "R7 halfword invalidate no pulse", 2'd1);
    wr(6'h04, 32'h0000_00FF, "R7 reserved size no flush", 2'd3);
    rd(6'h00, "R7 ctrl unchanged");
    rd(6'h04, "R7 pte high unchanged");
    rd(6'h24, "R7 unmapped read returns zero");

    // R8 hardware event load
    wr(6'h1C, 32'h0000_0111, "R8 bus write with hw update", 2'd2, 1, 11'h5A0, 11'h3C0);
    rd(6'h1C, "R8 hw exc wins");
    rd(6'h20, "R8 hw irq loaded");
    wr(6'h18, 32'h0000_0222, "R8 hw update beside trap write", 2'd2, 1, 11'h7FF, 11'h001);
    rd(6'h18, "R8 trap from bus");
    rd(6'h1C, "R8 exc second load");
    rd(6'h20, "R8 irq second load");
    idle("final idle");
    idle("drain");
    repeat (3) @(negedge clk);
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule